// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. A lookup selects one counter by XORing word-aligned fetch address bits with a register of recent branch outcomes. The counter's upper half means "taken". Because recent global outcomes are folded into the index, the same branch can learn a different answer in each history context. This lets it follow patterns that a per-address counter alone cannot.

The front end sends a lookup on a valid/ready request channel. The answer comes back one cycle later on a valid/ready response channel. The answer carries the predicted direction and the table index that was used. A request is accepted only when the response register is empty or is being drained in the same cycle. While the consumer holds `rsp_ready` low, the response stays frozen and `req_ready` stays low. When the branch resolves, the back end returns that saved index together with the real outcome on the update port. The update port never applies back-pressure. Setting the history length to zero turns the block into a plain per-address (bimodal) predictor.

Top module: `gshare_predictor`

## Requirements
- R1: After reset, every counter holds 2 (weakly taken) and the history register is zero. The first lookup of any address therefore predicts taken, and `rsp_valid` is low.
- R2: Counter values are encoded 0 = strong not-taken, 1 = weak not-taken, 2 = weak taken, 3 = strong taken. `rsp_taken` is 1 exactly when the selected counter is 2 or 3.
- R3: An update with outcome taken raises the addressed counter by one, stopping at 3. An update with outcome not-taken lowers it by one, stopping at 0.
- R4: The lookup index is `req_pc[IDX_W+1:2]` XOR the history register, with history bit 0 aligned to index bit 0. This index is returned on `rsp_idx`.
- R5: Every update shifts the history left by one place and inserts 1 for taken or 0 for not-taken at bit 0. The history is HIST_W bits wide.
- R6: An update writes the counter at `upd_idx` as supplied. The write does not depend on the history present when the update arrives.
- R7: If a lookup and an update hit the same entry in the same cycle, the response reflects the counter value from before that update.
- R8: A request is accepted when `req_valid` and `req_ready` are both high, and `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_taken` and `rsp_idx` hold their values.
- R9: `upd_ready` is always high, so an update is applied in the same cycle that `upd_valid` is high.
- R10: With HIST_W = 0, a branch that strictly alternates taken / not-taken, starting from the reset state, mispredicts on every not-taken outcome. That is 10 misses in 20 branches.
- R11: With HIST_W = 6, a loop branch that repeats 9 taken then 1 not-taken mispredicts exactly once per iteration after a warm-up of four iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_pc | input | PC_W | Fetch address of the branch |
| rsp_valid | output | 1 | Prediction result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_taken | output | 1 | Predicted direction, 1 = taken |
| rsp_idx | output | IDX_W | Table index used for this prediction |
| upd_valid | input | 1 | Resolved outcome present |
| upd_ready | output | 1 | Always 1 |
| upd_idx | input | IDX_W | Index captured at prediction time |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
Several properties are checked on every cycle:
- counter saturation and the single-step rule at each written entry;
- the history shift after each update;
- the index carried into the response register;
- the frozen response and lowered `req_ready` under back-pressure.

The bench scenarios cover the rest:
- the reset-time weakly-taken answers;
- the old-value result when a lookup and an update collide on one entry;
- updates that land on a supplied index regardless of history;
- the learned behaviour over many branches, that is, the one-miss-per-iteration loop and the repeated misses of the alternating branch in bimodal mode.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd2;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;

  function automatic ctr_t ctr_step(input ctr_t c, input logic tk);
    if (tk) return (c == CTR_MAX) ? c : ctr_t'(c + 2'd1);
    else    return (c == CTR_MIN) ? c : ctr_t'(c - 2'd1);
  endfunction

  function automatic logic ctr_dir(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/gshare_hist.sv
module gshare_hist #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_bit,
  output logic [IDX_W-1:0] mix
);
  generate
    if (HIST_W == 0) begin : g_none
      logic unused_hist;
      assign unused_hist = ^{clk, rst_n, shift_en, shift_bit};
      assign mix = '0;
    end else begin : g_reg
      logic [HIST_W-1:0] h;
      always_ff @(posedge clk) begin
        if (!rst_n)        h <= '0;
        else if (shift_en) h <= {h[HIST_W-2 >= 0 ? HIST_W-2 : 0 : 0] & {(HIST_W > 1 ? HIST_W-1 : 1){HIST_W > 1}}, shift_bit} >> 0;
      end
      always_comb begin
        mix = '0;
        mix[HIST_W-1:0] = h;
      end

      p_newbit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> h[0] == $past(shift_bit));
      p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(h));
      if (HIST_W > 1) begin : g_chk
        p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
          shift_en |=> h[HIST_W-1:1] == $past(h[HIST_W-2:0]));
      end
    end
  endgenerate
endmodule

// File: rtl/gshare_index.sv
module gshare_index #(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] pc_word,
  input  logic [IDX_W-1:0] mix,
  output logic [IDX_W-1:0] idx
);
  assign idx = pc_word ^ mix;
endmodule

// File: rtl/gshare_table.sv
module gshare_table
  import gshare_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(mem[wr_idx], wr_taken);
    end
  end

  assign rd_ctr = mem[rd_idx];

  p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && mem[wr_idx] == CTR_MAX) |=> mem[$past(wr_idx)] == CTR_MAX);
  p_sat_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && mem[wr_idx] == CTR_MIN) |=> mem[$past(wr_idx)] == CTR_MIN);
  p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && mem[wr_idx] != CTR_MAX)
      |=> mem[$past(wr_idx)] == ctr_t'($past(mem[wr_idx]) + 2'd1));
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && mem[wr_idx] != CTR_MIN)
      |=> mem[$past(wr_idx)] == ctr_t'($past(mem[wr_idx]) - 2'd1));
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PC_W-1:0]  req_pc,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_taken,
  output logic [IDX_W-1:0] rsp_idx,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  logic [IDX_W-1:0] hist_mix;
  logic [IDX_W-1:0] look_idx;
  logic [IDX_W-1:0] pc_word;
  ctr_t             look_ctr;
  logic             req_fire;
  logic             unused_pc;

  assign pc_word   = req_pc[IDX_W+1:2];
  assign unused_pc = ^{req_pc[PC_W-1:IDX_W+2], req_pc[1:0]};
  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign upd_ready = 1'b1;

  gshare_hist #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(upd_valid), .shift_bit(upd_taken), .mix(hist_mix)
  );

  gshare_index #(.IDX_W(IDX_W)) u_index (
    .pc_word(pc_word), .mix(hist_mix), .idx(look_idx)
  );

  gshare_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .rd_idx(look_idx), .rd_ctr(look_ctr),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_taken(upd_taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_taken <= 1'b0;
      rsp_idx   <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_taken <= ctr_dir(look_ctr);
      rsp_idx   <= look_idx;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_idx) && $stable(rsp_taken));
  p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  p_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_idx == ($past(req_pc[IDX_W+1:2]) ^ $past(hist_mix)));
  p_upd_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ready);
endmodule

// File: tb/sim_gshare_predictor.sv
module sim_gshare_predictor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [31:0] req_pc = '0;
  logic        rsp_ready = 1'b1;
  logic        upd_valid = 1'b0;
  logic        upd_taken = 1'b0;
  logic [5:0]  upd_idx0 = '0, upd_idx1 = '0;

  logic req_ready0, rsp_valid0, rsp_taken0, upd_ready0;
  logic req_ready1, rsp_valid1, rsp_taken1, upd_ready1;
  logic [5:0] rsp_idx0, rsp_idx1;

  gshare_predictor #(.PC_W(32), .IDX_W(6), .HIST_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready0), .req_pc(req_pc),
    .rsp_valid(rsp_valid0), .rsp_ready(rsp_ready), .rsp_taken(rsp_taken0), .rsp_idx(rsp_idx0),
    .upd_valid(upd_valid), .upd_ready(upd_ready0), .upd_idx(upd_idx0), .upd_taken(upd_taken));

  gshare_predictor #(.PC_W(32), .IDX_W(6), .HIST_W(0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready1), .req_pc(req_pc),
    .rsp_valid(rsp_valid1), .rsp_ready(rsp_ready), .rsp_taken(rsp_taken1), .rsp_idx(rsp_idx1),
    .upd_valid(upd_valid), .upd_ready(upd_ready1), .upd_idx(upd_idx1), .upd_taken(upd_taken));

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic [5:0] hist_m = '0;

  // each vector: {pc, outcome, expected prediction, expected index} for the bimodal instance
  localparam logic [39:0] VEC [10] = '{
    {32'h44, 1'b1, 1'b1, 6'd17},
    {32'h40, 1'b1, 1'b1, 6'd16},
    {32'h40, 1'b1, 1'b1, 6'd16},
    {32'h40, 1'b0, 1'b1, 6'd16},
    {32'h40, 1'b0, 1'b1, 6'd16},
    {32'h40, 1'b0, 1'b0, 6'd16},
    {32'h40, 1'b0, 1'b0, 6'd16},
    {32'h40, 1'b1, 1'b0, 6'd16},
    {32'h40, 1'b1, 1'b0, 6'd16},
    {32'h40, 1'b1, 1'b1, 6'd16}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pred_only(input logic [31:0] pc, output bit p0, output logic [5:0] i0,
                           output bit p1, output logic [5:0] i1);
    @(negedge clk);
    req_valid = 1'b1; req_pc = pc;
    @(negedge clk);
    req_valid = 1'b0;
    p0 = rsp_taken0; i0 = rsp_idx0; p1 = rsp_taken1; i1 = rsp_idx1;
  endtask

  task automatic upd_only(input logic [5:0] i0, input logic [5:0] i1, input bit tk);
    upd_valid = 1'b1; upd_taken = tk; upd_idx0 = i0; upd_idx1 = i1;
    @(negedge clk);
    upd_valid = 1'b0;
    hist_m = {hist_m[4:0], tk};
  endtask

  task automatic do_branch(input logic [31:0] pc, input bit tk, output bit p0, output logic [5:0] i0,
                           output bit p1, output logic [5:0] i1);
    pred_only(pc, p0, i0, p1, i1);
    upd_only(i0, i1, tk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit p0, p1;
    logic [5:0] i0, i1, e0;
    logic [31:0] pc;
    int miss;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R8 / R9 reset state
    chk(rsp_valid0 == 0 && rsp_valid1 == 0, "R1", "rsp_valid after reset", rsp_valid0, 0);
    chk(req_ready0 == 1, "R8", "req_ready when empty", req_ready0, 1);
    chk(upd_ready0 == 1 && upd_ready1 == 1, "R9", "upd_ready", upd_ready0, 1);

    // R4 / R5 index with history bits entering at bit 0
    pc = 32'hA8;
    e0 = pc[7:2] ^ hist_m;
    do_branch(pc, 1'b1, p0, i0, p1, i1);
    chk(i0 == e0 && i0 == 6'd42, "R4", "index from reset history", i0, e0);
    chk(p0 == 1, "R1", "first lookup predicts taken", p0, 1);
    e0 = pc[7:2] ^ hist_m;
    do_branch(pc, 1'b0, p0, i0, p1, i1);
    chk(i0 == 6'd43 && i0 == e0, "R5", "history after taken", i0, 43);
    e0 = pc[7:2] ^ hist_m;
    do_branch(pc, 1'b1, p0, i0, p1, i1);
    chk(i0 == 6'd40 && i0 == e0, "R5", "history after not-taken", i0, 40);
    pred_only(pc, p0, i0, p1, i1);
    chk(i0 == 6'd47, "R5", "history after three outcomes", i0, 47);

    // R2 / R3 vector walk on bimodal instance
    for (int v = 0; v < 10; v++) begin
      do_branch(VEC[v][39:8], VEC[v][7], p0, i0, p1, i1);
      chk(p1 == VEC[v][6], "R3", $sformatf("vector %0d direction (R2)", v), p1, VEC[v][6]);
      chk(i1 == VEC[v][5:0], "R4", $sformatf("vector %0d bimodal index", v), i1, VEC[v][5:0]);
    end

    // R6 update lands at the supplied index
    repeat (3) upd_only(6'd5, 6'd5, 1'b0);
    pc = {24'h0, (6'd5 ^ hist_m), 2'b00};
    pred_only(pc, p0, i0, p1, i1);
    chk(i0 == 6'd5, "R6", "lookup reaches index 5", i0, 5);
    chk(p0 == 0, "R6", "index 5 trained not-taken", p0, 0);

    // R7 same-cycle lookup and update on one entry
    repeat (3) upd_only(6'd9, 6'd9, 1'b1);
    upd_only(6'd9, 6'd9, 1'b0);
    pc = {24'h0, (6'd9 ^ hist_m), 2'b00};
    @(negedge clk);
    req_valid = 1'b1; req_pc = pc;
    upd_valid = 1'b1; upd_taken = 1'b0; upd_idx0 = 6'd9; upd_idx1 = 6'd9;
    @(negedge clk);
    req_valid = 1'b0; upd_valid = 1'b0;
    hist_m = {hist_m[4:0], 1'b0};
    chk(rsp_idx0 == 6'd9, "R7", "collision index", rsp_idx0, 9);
    chk(rsp_taken0 == 1, "R7", "collision returns old value", rsp_taken0, 1);
    pc = {24'h0, (6'd9 ^ hist_m), 2'b00};
    pred_only(pc, p0, i0, p1, i1);
    chk(p0 == 0 && i0 == 6'd9, "R7", "entry after collision write", p0, 0);

    // R8 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_pc = 32'h10;
    @(negedge clk);
    chk(rsp_valid0 == 1 && rsp_idx0 == (6'd4 ^ hist_m), "R8", "first response", rsp_idx0, 6'd4 ^ hist_m);
    req_pc = 32'h14;
    chk(req_ready0 == 0, "R8", "req_ready low while stalled", req_ready0, 0);
    @(negedge clk);
    chk(rsp_valid0 == 1 && rsp_idx0 == (6'd4 ^ hist_m), "R8", "response held", rsp_idx0, 6'd4 ^ hist_m);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid0 == 1 && rsp_idx0 == (6'd5 ^ hist_m), "R8", "second response after drain", rsp_idx0, 6'd5 ^ hist_m);
    @(negedge clk);
    chk(rsp_valid0 == 0, "R8", "response drained", rsp_valid0, 0);

    // R10 bimodal alternating branch on fresh entry 32
    miss = 0;
    for (int k = 0; k < 20; k++) begin
      do_branch(32'h80, (k % 2) == 0, p0, i0, p1, i1);
      if (p1 != ((k % 2) == 0)) miss++;
    end
    chk(miss == 10, "R10", "bimodal alternating misses", miss, 10);

    // gshare learns the same alternation
    for (int k = 0; k < 12; k++) do_branch(32'h300, (k % 2) == 0, p0, i0, p1, i1);
    miss = 0;
    for (int k = 0; k < 12; k++) begin
      do_branch(32'h300, (k % 2) == 0, p0, i0, p1, i1);
      if (p0 != ((k % 2) == 0)) miss++;
    end
    chk(miss == 0, "R4", "history-indexed alternating misses", miss, 0);

    // R11 loop pattern 9 taken, 1 not-taken
    for (int it = 0; it < 8; it++) begin
      miss = 0;
      for (int k = 0; k < 10; k++) begin
        do_branch(32'h200, k != 9, p0, i0, p1, i1);
        if (p0 != (k != 9)) miss++;
      end
      if (it >= 4) chk(miss == 1, "R11", $sformatf("loop iteration %0d misses", it), miss, 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule